// File: doc/BRIEF.md
# Programmable horizontal line segment sequencer

The block produces the horizontal timing of one video line as a chain of segments. Each segment has its own programmed length, counted in pixel-clock (PCK) cycles. PCK is derived inside the block as an enable on every second edge of the input clock. When a line starts, the block takes a 4-bit line-type identifier and selects the ordered segment list for that type. Equalization, serration, mixed, blank, video and half lines each use a different list of segments. While a line runs, the block reports the current segment code, three mutually exclusive sync, blank and active flags, and an end-of-line strobe.

Segment lengths are held in a byte-wide register file that is written through an address/data port. Four of the segments have 10-bit lengths. Their upper two bits share one packed byte. When a line is accepted, the block copies every length into a shadow store. A write therefore never changes a line that is already running.

Top module: `hline_seq`

## Requirements
- R1: The sequencer advances only on pixel-clock ticks. `pck_en_o` is high on every second clock cycle and low on the others. Outputs change only on the clock edge that ends a cycle with `pck_en_o` high.
- R2: A segment with programmed length N lasts exactly N PCK cycles. Lengths are written at these addresses: 0 sync, 1 breezeway, 2 burst, 3 back porch, 4 half back porch, 5 active, 6 short active, 7 half active, 8 equalizing low, 9 equalizing high, 10 serration low, 11 serration high, 12 front porch. Address 13 holds the upper length bits: half back porch in bits 7-6, active in 5-4, half active in 3-2, short active in 1-0. Writes to addresses 14 and 15 are ignored. `seg_o` reports segment code = address + 1, and 0 when idle.
- R3: The four-segment types follow these orders. IDs 0x0 and 0xA: eq-low, eq-high, eq-low, eq-high. ID 0x2: ser-low, ser-high, eq-low, eq-high. ID 0x3: ser-low, ser-high, ser-low, ser-high. ID 0x1: eq-low, eq-high, ser-low, ser-high.
- R4: The longer types follow these orders. IDs 0x5/0xD (blank) and 0x7/0xF (video): sync, breezeway, burst, back porch, active, front porch. IDs 0x4/0xC: sync, breezeway, burst, back porch, short active, front porch, eq-low, eq-high. ID 0xE with `half_dis_i` low: sync, breezeway, burst, half back porch, half active, front porch.
- R5: ID 0xE with `half_dis_i` high runs as a blank line (0xD). The IDs 0x6, 0x8, 0x9 and 0xB also run as blank lines.
- R6: `sync_o` is high in sync, eq-low and ser-low. `active_o` is high in active, short active and half active, except in blank-type lines. `blank_o` is high otherwise, including when idle. Exactly one of the three flags is high at any time.
- R7: A segment of length zero is skipped and takes no cycle. A line whose segments are all zero leaves the block idle.
- R8: `eol_o` is high for exactly the last PCK cycle of the final segment, and the block is idle afterwards. A start is accepted on a tick only when the block is idle or in that last cycle. A start at any other time is ignored.
- R9: Register writes affect only lines accepted after the write. The line in progress keeps its lengths.
- R10: During reset `seg_o` is 0, `blank_o` is 1, and `sync_o`, `active_o`, `eol_o` and `pck_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| half_dis_i | input | 1 | High turns half-line requests into blank lines |
| line_start_i | input | 1 | Line start request, sampled on a tick |
| line_id_i | input | 4 | Line-type identifier for the requested line |
| pck_en_o | output | 1 | Pixel-clock tick enable |
| seg_o | output | 4 | Current segment code |
| sync_o | output | 1 | Sync flag |
| blank_o | output | 1 | Blank flag |
| active_o | output | 1 | Active-video flag |
| eol_o | output | 1 | End-of-line strobe |

## Verification
The properties assume that `line_start_i` is the only input that can end idleness or replace a finished line. They also assume that a request is held for a whole PCK period around the tick it targets. The stimulus drives every request and every write on falling edges, aligned with the observed `pck_en_o` phase. It clears start requests on the next falling edge, so each request spans exactly one tick. Randomized lengths stay small, and the upper length bits are set only in directed cases. This keeps long lines within the run time while still reaching the 10-bit range.

// File: rtl/hline_pkg.sv
package hline_pkg;
  localparam int DAT_W = 8;
  localparam int LEN_W = 10;
  localparam int HI_W  = LEN_W - DAT_W;
  localparam int ADR_W = 4;
  localparam int ID_W  = 4;
  localparam int NSEG  = 14;   // codes incl. idle
  localparam int NSTEP = 8;
  localparam int STP_W = $clog2(NSTEP);

  typedef enum logic [3:0] {
    SEG_IDLE, SEG_SYNC, SEG_BRZ, SEG_BURST, SEG_BP, SEG_BPX, SEG_ACT,
    SEG_ACTS, SEG_ACTH, SEG_EQL, SEG_EQH, SEG_SERL, SEG_SERH, SEG_FP
  } seg_e;

  typedef enum logic [2:0] {
    LK_EQEQ, LK_SEREQ, LK_SERSER, LK_EQSER, LK_BLANK, LK_VIDEO, LK_VIDEQ, LK_HALF
  } kind_e;

  function automatic kind_e decode_kind(logic [ID_W-1:0] id, logic half_dis);
    case (id)
      4'h0, 4'hA: return LK_EQEQ;
      4'h2:       return LK_SEREQ;
      4'h3:       return LK_SERSER;
      4'h1:       return LK_EQSER;
      4'h7, 4'hF: return LK_VIDEO;
      4'h4, 4'hC: return LK_VIDEQ;
      4'hE:       return half_dis ? LK_BLANK : LK_HALF;
      default:    return LK_BLANK;
    endcase
  endfunction

  function automatic seg_e step_code(kind_e k, logic [STP_W-1:0] s);
    seg_e t [NSTEP];
    for (int i = 0; i < NSTEP; i++) t[i] = SEG_IDLE;
    case (k)
      LK_EQEQ:   begin t[0]=SEG_EQL;  t[1]=SEG_EQH;  t[2]=SEG_EQL;  t[3]=SEG_EQH;  end
      LK_SEREQ:  begin t[0]=SEG_SERL; t[1]=SEG_SERH; t[2]=SEG_EQL;  t[3]=SEG_EQH;  end
      LK_SERSER: begin t[0]=SEG_SERL; t[1]=SEG_SERH; t[2]=SEG_SERL; t[3]=SEG_SERH; end
      LK_EQSER:  begin t[0]=SEG_EQL;  t[1]=SEG_EQH;  t[2]=SEG_SERL; t[3]=SEG_SERH; end
      default: begin
        t[0] = SEG_SYNC; t[1] = SEG_BRZ; t[2] = SEG_BURST; t[5] = SEG_FP;
        t[3] = (k == LK_HALF) ? SEG_BPX : SEG_BP;
        t[4] = (k == LK_HALF) ? SEG_ACTH : (k == LK_VIDEQ) ? SEG_ACTS : SEG_ACT;
        if (k == LK_VIDEQ) begin t[6] = SEG_EQL; t[7] = SEG_EQH; end
      end
    endcase
    return t[s];
  endfunction
endpackage

// File: rtl/hline_regfile.sv
module hline_regfile
  import hline_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADR_W-1:0]            wr_addr_i,
  input  logic [DAT_W-1:0]            wr_data_i,
  input  logic                        snap_i,
  output logic [NSEG-1:0][LEN_W-1:0]  live_len_o,
  output logic [NSEG-1:0][LEN_W-1:0]  shd_len_o
);
  localparam int NLO = NSEG - 1;

  logic [NLO-1:0][DAT_W-1:0] lo_q;
  logic [DAT_W-1:0]          hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en_i) begin
      if (int'(wr_addr_i) < NLO) lo_q[wr_addr_i] <= wr_data_i;
      else if (int'(wr_addr_i) == NLO) hi_q <= wr_data_i;
    end
  end

  // packed upper bits for the four long segments
  function automatic logic [HI_W-1:0] hi_of(int code, logic [DAT_W-1:0] h);
    case (code)
      int'(SEG_BPX):  return h[7:6];
      int'(SEG_ACT):  return h[5:4];
      int'(SEG_ACTH): return h[3:2];
      int'(SEG_ACTS): return h[1:0];
      default:        return '0;
    endcase
  endfunction

  assign live_len_o[0] = '0;
  for (genvar g = 1; g < NSEG; g++) begin : g_len
    assign live_len_o[g] = {hi_of(g, hi_q), lo_q[g-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shd_len_o <= '0;
    else if (snap_i) shd_len_o <= live_len_o;
  end
endmodule

// File: rtl/hline_finder.sv
module hline_finder
  import hline_pkg::*;
(
  input  kind_e                       kind_i,
  input  logic [STP_W:0]              from_i,
  input  logic [NSEG-1:0][LEN_W-1:0]  len_i,
  output logic                        found_o,
  output logic [STP_W-1:0]            idx_o,
  output logic [LEN_W-1:0]            len_o
);
  // lowest step >= from_i with a real, nonzero segment
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    len_o   = '0;
    for (int i = NSTEP - 1; i >= 0; i--) begin
      if ((STP_W+1)'(i) >= from_i) begin
        if (step_code(kind_i, STP_W'(i)) != SEG_IDLE &&
            len_i[step_code(kind_i, STP_W'(i))] != '0) begin
          found_o = 1'b1;
          idx_o   = STP_W'(i);
          len_o   = len_i[step_code(kind_i, STP_W'(i))];
        end
      end
    end
  end
endmodule

// File: rtl/hline_seq.sv
module hline_seq
  import hline_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADR_W-1:0] wr_addr_i,
  input  logic [DAT_W-1:0] wr_data_i,
  input  logic             half_dis_i,
  input  logic             line_start_i,
  input  logic [ID_W-1:0]  line_id_i,
  output logic             pck_en_o,
  output logic [3:0]       seg_o,
  output logic             sync_o,
  output logic             blank_o,
  output logic             active_o,
  output logic             eol_o
);
  logic                       ph_q, run_q, accept, last;
  kind_e                      kind_q, new_kind;
  logic [STP_W-1:0]           step_q;
  logic [LEN_W-1:0]           cnt_q;
  logic [NSEG-1:0][LEN_W-1:0] live_len, shd_len;
  logic                       fst_found, nxt_found;
  logic [STP_W-1:0]           fst_idx, nxt_idx;
  logic [LEN_W-1:0]           fst_len, nxt_len;
  seg_e                       cur;

  assign pck_en_o = ph_q;
  assign new_kind = decode_kind(line_id_i, half_dis_i);

  hline_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .snap_i(accept), .live_len_o(live_len), .shd_len_o(shd_len)
  );

  hline_finder u_first (
    .kind_i(new_kind), .from_i('0), .len_i(live_len),
    .found_o(fst_found), .idx_o(fst_idx), .len_o(fst_len)
  );

  hline_finder u_next (
    .kind_i(kind_q), .from_i({1'b0, step_q} + (STP_W+1)'(1)), .len_i(shd_len),
    .found_o(nxt_found), .idx_o(nxt_idx), .len_o(nxt_len)
  );

  assign last   = run_q && (cnt_q == '0) && !nxt_found;
  assign accept = ph_q && line_start_i && (!run_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      run_q  <= 1'b0;
      kind_q <= LK_BLANK;
      step_q <= '0;
      cnt_q  <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        if (accept) begin
          run_q  <= fst_found;
          kind_q <= new_kind;
          step_q <= fst_idx;
          cnt_q  <= fst_len - LEN_W'(1);
        end else if (run_q) begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
          end else if (nxt_found) begin
            step_q <= nxt_idx;
            cnt_q  <= nxt_len - LEN_W'(1);
          end else begin
            run_q <= 1'b0;
          end
        end
      end
    end
  end

  assign cur      = run_q ? step_code(kind_q, step_q) : SEG_IDLE;
  assign seg_o    = cur;
  assign sync_o   = cur inside {SEG_SYNC, SEG_EQL, SEG_SERL};
  assign active_o = (cur inside {SEG_ACT, SEG_ACTS, SEG_ACTH}) && (kind_q != LK_BLANK);
  assign blank_o  = !sync_o && !active_o;
  assign eol_o    = last;
endmodule

// File: rtl/hline_seq_chk.sv
module hline_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_start_i,
  input logic       pck_en_o,
  input logic [3:0] seg_o,
  input logic       sync_o,
  input logic       blank_o,
  input logic       active_o,
  input logic       eol_o
);
  p_tick_alt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pck_en_o |=> !pck_en_o);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pck_en_o |=> ($stable(seg_o) && $stable(eol_o)));

  p_one_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sync_o, blank_o, active_o}) == 1);

  p_sync_seg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (seg_o == 4'd1 || seg_o == 4'd9 || seg_o == 4'd11));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 4'd0) |-> (blank_o && !eol_o));

  p_eol_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_o && pck_en_o && !line_start_i) |=> (seg_o == 4'd0));

  p_idle_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 4'd0 && pck_en_o && !line_start_i) |=> (seg_o == 4'd0));
endmodule

bind hline_seq hline_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
  .pck_en_o(pck_en_o), .seg_o(seg_o), .sync_o(sync_o),
  .blank_o(blank_o), .active_o(active_o), .eol_o(eol_o)
);

// File: tb/hline_seq_bench.sv
`timescale 1ns/1ps
module hline_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       half_dis_i = 1'b0;
  logic       line_start_i = 1'b0;
  logic [3:0] line_id_i = '0;
  logic       pck_en_o, sync_o, blank_o, active_o, eol_o;
  logic [3:0] seg_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_lo [13];
  logic [7:0] m_hi;

  always #5 clk_i = ~clk_i;

  hline_seq u_hline_seq (.*);

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // 0 eqeq,1 sereq,2 serser,3 eqser,4 blank,5 video,6 videq,7 half
  function automatic int m_kind(int id, bit hd);
    case (id)
      0, 10: return 0;
      2: return 1;
      3: return 2;
      1: return 3;
      7, 15: return 5;
      4, 12: return 6;
      14: return hd ? 4 : 7;
      default: return 4;
    endcase
  endfunction

  function automatic int m_code(int k, int s);
    int eq [4] = '{9, 10, 9, 10};
    int se [4] = '{11, 12, 9, 10};
    int ss [4] = '{11, 12, 11, 12};
    int es [4] = '{9, 10, 11, 12};
    int bl [8] = '{1, 2, 3, 4, 6, 13, 0, 0};
    int ve [8] = '{1, 2, 3, 4, 7, 13, 9, 10};
    int hf [8] = '{1, 2, 3, 5, 8, 13, 0, 0};
    case (k)
      0: return s < 4 ? eq[s] : 0;
      1: return s < 4 ? se[s] : 0;
      2: return s < 4 ? ss[s] : 0;
      3: return s < 4 ? es[s] : 0;
      6: return ve[s];
      7: return hf[s];
      default: return bl[s];
    endcase
  endfunction

  function automatic int m_len(int code, logic [7:0] lo [13], logic [7:0] hi);
    int u;
    if (code == 0) return 0;
    case (code)
      5: u = hi[7:6];
      6: u = hi[5:4];
      8: u = hi[3:2];
      7: u = hi[1:0];
      default: u = 0;
    endcase
    return u * 256 + lo[code-1];
  endfunction

  task automatic wr(int a, int d);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
    if (a < 13) m_lo[a] = 8'(d); else if (a == 13) m_hi = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic align();
    if (!pck_en_o) @(negedge clk_i);
  endtask

  task automatic idle_chk(string tag);
    @(negedge clk_i);
    chk(seg_o == 0, tag, "idle seg", seg_o, 0);
    chk(blank_o && !sync_o && !active_o && !eol_o, tag, "idle flags",
        {blank_o, sync_o, active_o, eol_o}, 8);
    @(negedge clk_i);
  endtask

  // called at a falling edge with pck_en_o high
  task automatic run_line(int id, bit hd, bit spur, bit midw, string tag);
    logic [7:0] s_lo [13];
    logic [7:0] s_hi;
    int k, lastw, total, n;
    s_lo = m_lo; s_hi = m_hi;
    k = m_kind(id, hd);
    lastw = -1; total = 0; n = 0;
    for (int s = 0; s < 8; s++)
      if (m_code(k, s) != 0 && m_len(m_code(k, s), s_lo, s_hi) != 0) begin
        lastw = s; total += m_len(m_code(k, s), s_lo, s_hi);
      end
    line_start_i = 1'b1; line_id_i = 4'(id); half_dis_i = hd;
    if (total == 0) begin
      @(negedge clk_i);
      line_start_i = 1'b0;
      chk(seg_o == 0 && !eol_o, "R7", "all-zero line", seg_o, 0);
      @(negedge clk_i);
      return;
    end
    for (int s = 0; s < 8; s++) begin
      int code, len;
      code = m_code(k, s);
      len = m_len(code, s_lo, s_hi);
      if (code == 0 || len == 0) continue;
      for (int c = 0; c < len; c++) begin
        bit e, sy, ac;
        @(negedge clk_i);
        line_start_i = 1'b0;
        e  = (s == lastw) && (c == len - 1);
        sy = (code == 1 || code == 9 || code == 11);
        ac = (code == 6 || code == 7 || code == 8) && (k != 4);
        chk(seg_o == code, tag, "segment", seg_o, code);
        chk(sync_o == sy && active_o == ac && blank_o == !(sy || ac), "R6", "flags",
            {sync_o, active_o, blank_o}, {sy, ac, !(sy || ac)});
        chk(eol_o == e, "R8", "eol", eol_o, e);
        if (n == 0) chk(pck_en_o == 1'b0, "R1", "tick phase", pck_en_o, 0);
        if (midw && n == 0) begin
          int a;
          a = $urandom_range(0, 12);
          wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'($urandom_range(1, 3));
          m_lo[a] = wr_data_i;
        end
        @(negedge clk_i);
        wr_en_i = 1'b0;
        chk(seg_o == code, "R1", "held between ticks", seg_o, code);
        if (spur && n == 0 && total > 2) begin
          line_start_i = 1'b1; line_id_i = 4'($urandom_range(0, 15));
        end
        n++;
      end
    end
  endtask

  function automatic string tag_of(int id, bit hd);
    int k;
    k = m_kind(id, hd);
    return (k < 4) ? "R3" : (k == 4 && id != 5 && id != 13) ? "R5" : "R4";
  endfunction

  task automatic prog_small();
    for (int a = 0; a < 13; a++) wr(a, $urandom_range(0, 4));
    wr(13, 0);
    align();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 13; i++) m_lo[i] = '0;
    m_hi = '0;
    repeat (3) @(negedge clk_i);
    chk(seg_o == 0, "R10", "reset seg", seg_o, 0);
    chk(blank_o && !sync_o && !active_o && !eol_o && !pck_en_o, "R10", "reset outputs",
        {blank_o, sync_o, active_o, eol_o, pck_en_o}, 16);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pck_en_o == 1'b1, "R1", "first tick phase", pck_en_o, 1);

    // directed lengths
    wr(0, 2); wr(1, 1); wr(2, 2); wr(3, 1); wr(4, 2); wr(5, 3); wr(6, 2);
    wr(7, 1); wr(8, 1); wr(9, 2); wr(10, 2); wr(11, 1); wr(12, 1); wr(13, 0);
    wr(14, 9); wr(15, 9);     // R2: unmapped addresses ignored
    align();
    foreach (m_lo[i]) ;
    run_line(0, 0, 0, 0, "R3"); run_line(2, 0, 0, 0, "R3");
    run_line(3, 0, 0, 0, "R3"); run_line(1, 0, 0, 0, "R3");
    run_line(10, 0, 0, 0, "R3");
    idle_chk("R8");
    run_line(15, 0, 0, 0, "R4"); run_line(13, 0, 0, 0, "R4");
    run_line(12, 0, 0, 0, "R4"); run_line(14, 0, 0, 0, "R4");
    run_line(14, 1, 0, 0, "R5"); run_line(6, 0, 0, 0, "R5");
    run_line(9, 0, 0, 0, "R5"); run_line(5, 0, 0, 0, "R4");
    idle_chk("R8");

    // R7: zero-length segments skipped, all-zero line idle
    wr(1, 0); wr(5, 0); align();
    run_line(7, 0, 0, 0, "R7");
    wr(8, 0); wr(9, 0); align();
    run_line(0, 0, 0, 0, "R7");
    idle_chk("R7");

    // R2: 10-bit lengths through the packed upper byte
    wr(5, 3); wr(1, 1); wr(8, 1); wr(9, 1);
    wr(13, 8'b01_01_01_01); align();
    run_line(15, 0, 0, 0, "R2");
    run_line(14, 0, 0, 0, "R2");
    run_line(4, 0, 0, 0, "R2");
    wr(13, 0); align();

    // R9: write during a line affects only the next one
    run_line(13, 0, 0, 1, "R9");
    run_line(13, 0, 0, 0, "R9");
    // R8: start during a line ignored
    run_line(7, 0, 1, 0, "R8");
    idle_chk("R8");

    for (int i = 0; i < 60; i++) begin
      int id;
      bit hd;
      if (i % 8 == 0) prog_small();
      id = $urandom_range(0, 15);
      hd = 1'($urandom_range(0, 1));
      run_line(id, hd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
               tag_of(id, hd));
      if ($urandom_range(0, 3) == 0) idle_chk("R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule